// File: doc/BRIEF.md
# Address Range Match Comparator

This block watches a bus and reports whether each valid access lands inside or outside an address window. The window is set by two comparators. Comparator A holds the lower bound and comparator B holds the upper bound. A mode input selects the sense of the test. In inside mode, an access matches only when both comparators hit in the same cycle. In outside mode, an access matches when it is below the lower bound or above the upper bound, so a hit on either comparator is enough.

Word accesses are judged by their aligned address alone, which is the address with bit 0 forced to zero. A word that straddles a window edge therefore falls on the side where its even byte lies. The result is a registered pulse, one clock wide, for each qualifying access, together with registered hit flags for each comparator. A downstream sequencer consumes the pulse.

Top module: `addr_window_match`

## Requirements
- R1: In inside mode (`outside_i`=0), `match_o` is set when the effective address satisfies `cmp_a_addr_i` <= address <= `cmp_b_addr_i`, so that comparators A and B both hit on the same access.
- R2: In inside mode, an access that hits only one comparator (below A or above B) leaves `match_o` low.
- R3: In outside mode (`outside_i`=1), comparator A hits when address < `cmp_a_addr_i` and comparator B hits when address > `cmp_b_addr_i`. Either hit alone sets `match_o`.
- R4: When `word_i`=1, the effective address is `addr_i` with bit 0 cleared. In inside mode, a straddling word matches only if that aligned address is inside the window.
- R5: In outside mode, a straddling word matches only if its aligned address (bit 0 cleared) is outside the window.
- R6: Both bounds are inclusive and all comparisons are unsigned over the full 18-bit address.
- R7: With `cmp_b_addr_i` = 0x3FFFF, comparator B never hits in outside mode. With `cmp_a_addr_i` = 0x00000, comparator A never hits in outside mode.
- R8: Outputs are registered. An access presented with `valid_i` high in cycle n is reported in cycle n+1 only. When `valid_i` is low, all outputs are low in the next cycle.
- R9: If either comparator enable is low, `match_o` stays low. A disabled comparator's hit flag also stays low.
- R10: `hit_a_o` and `hit_b_o` report the individual comparator results for the mode in use, independent of the match decision.
- R11: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Bus access valid this cycle |
| addr_i | input | 18 | Bus address |
| word_i | input | 1 | 1 = aligned word access, 0 = byte access |
| cmp_a_addr_i | input | 18 | Comparator A address (lower bound) |
| cmp_b_addr_i | input | 18 | Comparator B address (upper bound) |
| cmp_a_en_i | input | 1 | Comparator A enable |
| cmp_b_en_i | input | 1 | Comparator B enable |
| outside_i | input | 1 | 0 = inside-range mode, 1 = outside-range mode |
| match_o | output | 1 | Range match pulse, registered |
| hit_a_o | output | 1 | Comparator A hit, registered |
| hit_b_o | output | 1 | Comparator B hit, registered |

## Verification
The bench drives accesses exactly on each bound and one address either side of it. An off-by-one or signed comparison would then either gain or lose a match at the edge. Word accesses at odd addresses straddle the bounds. A design that kept bit 0, or that tested the word's upper byte, would report the wrong side of the window. In inside mode the bench drives single-comparator hits, and it also drops one enable during otherwise matching traffic. A design that ORed the hits, or that ignored the enables, would pulse `match_o` in those cases. The bench also sets the bounds to the ends of the address space and leaves idle cycles between accesses. A design with stray outside hits at those ends, or with a pulse that stays high, would fail there.

// File: rtl/awm_pkg.sv
package awm_pkg;
  localparam int unsigned ADDR_W = 18;
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned CMP_LO = 0;
  localparam int unsigned CMP_HI = 1;

  typedef enum logic {
    MODE_INSIDE  = 1'b0,
    MODE_OUTSIDE = 1'b1
  } range_mode_e;
endpackage

// File: rtl/awm_align.sv
module awm_align #(
  parameter int unsigned AW = awm_pkg::ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          word_i,
  output logic [AW-1:0] eff_addr_o
);
  // word accesses are judged by their even byte only
  always_comb begin
    eff_addr_o    = addr_i;
    eff_addr_o[0] = addr_i[0] & ~word_i;
  end
endmodule

// File: rtl/awm_cmp.sv
module awm_cmp #(
  parameter int unsigned AW    = awm_pkg::ADDR_W,
  parameter bit          UPPER = 1'b0
) (
  input  logic              [AW-1:0] addr_i,
  input  logic              [AW-1:0] bound_i,
  input  logic                       en_i,
  input  awm_pkg::range_mode_e       mode_i,
  output logic                       hit_o
);
  logic in_side;

  generate
    if (UPPER) begin : g_upper
      assign in_side = (addr_i <= bound_i);
    end else begin : g_lower
      assign in_side = (addr_i >= bound_i);
    end
  endgenerate

  always_comb begin
    if (!en_i) hit_o = 1'b0;
    else if (mode_i == awm_pkg::MODE_OUTSIDE) hit_o = ~in_side;
    else hit_o = in_side;
  end
endmodule

// File: rtl/awm_qual.sv
module awm_qual (
  input  logic                 hit_lo_i,
  input  logic                 hit_hi_i,
  input  logic                 en_lo_i,
  input  logic                 en_hi_i,
  input  awm_pkg::range_mode_e mode_i,
  output logic                 match_o
);
  logic pair_en;
  assign pair_en = en_lo_i & en_hi_i;

  always_comb begin
    if (!pair_en) match_o = 1'b0;
    else if (mode_i == awm_pkg::MODE_OUTSIDE) match_o = hit_lo_i | hit_hi_i;
    else match_o = hit_lo_i & hit_hi_i;
  end
endmodule

// File: rtl/addr_window_match.sv
module addr_window_match #(
  parameter int unsigned AW = awm_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          word_i,
  input  logic [AW-1:0] cmp_a_addr_i,
  input  logic [AW-1:0] cmp_b_addr_i,
  input  logic          cmp_a_en_i,
  input  logic          cmp_b_en_i,
  input  logic          outside_i,
  output logic          match_o,
  output logic          hit_a_o,
  output logic          hit_b_o
);
  import awm_pkg::*;

  localparam int unsigned NC = NUM_CMP;

  range_mode_e      mode;
  logic [AW-1:0]    eff_addr;
  logic [AW-1:0]    bound [NC];
  logic [NC-1:0]    en;
  logic [NC-1:0]    hit;
  logic             match_d;

  assign mode          = range_mode_e'(outside_i);
  assign bound[CMP_LO] = cmp_a_addr_i;
  assign bound[CMP_HI] = cmp_b_addr_i;
  assign en            = {cmp_b_en_i, cmp_a_en_i};

  awm_align #(.AW(AW)) u_align (
    .addr_i    (addr_i),
    .word_i    (word_i),
    .eff_addr_o(eff_addr)
  );

  for (genvar g = 0; g < NC; g++) begin : g_cmp
    awm_cmp #(.AW(AW), .UPPER(g == CMP_HI)) u_cmp (
      .addr_i (eff_addr),
      .bound_i(bound[g]),
      .en_i   (en[g]),
      .mode_i (mode),
      .hit_o  (hit[g])
    );
  end

  awm_qual u_qual (
    .hit_lo_i(hit[CMP_LO]),
    .hit_hi_i(hit[CMP_HI]),
    .en_lo_i (en[CMP_LO]),
    .en_hi_i (en[CMP_HI]),
    .mode_i  (mode),
    .match_o (match_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o <= 1'b0;
      hit_a_o <= 1'b0;
      hit_b_o <= 1'b0;
    end else begin
      match_o <= valid_i & match_d;
      hit_a_o <= valid_i & hit[CMP_LO];
      hit_b_o <= valid_i & hit[CMP_HI];
    end
  end

  // R8
  match_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(valid_i));
  // R1
  inside_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !$past(outside_i)) |-> (hit_a_o && hit_b_o));
  // R3
  match_has_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (hit_a_o || hit_b_o));
  // R9
  pair_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmp_a_en_i && cmp_b_en_i) |-> !match_o);
  // R9
  hit_a_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_a_o |-> $past(valid_i && cmp_a_en_i));
  // R7
  top_end_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(outside_i && (&cmp_b_addr_i)) |-> !hit_b_o);
  // R7
  bottom_end_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(outside_i && (cmp_a_addr_i == '0)) |-> !hit_a_o);
endmodule

// File: tb/addr_window_match_tb.sv
`timescale 1ns/1ps
module addr_window_match_tb_top;
  localparam int AW = 18;
  localparam int MAXA = (1 << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          word_i = 1'b0;
  logic [AW-1:0] cmp_a_addr_i = '0;
  logic [AW-1:0] cmp_b_addr_i = '0;
  logic          cmp_a_en_i = 1'b0;
  logic          cmp_b_en_i = 1'b0;
  logic          outside_i = 1'b0;
  logic          match_o, hit_a_o, hit_b_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  addr_window_match #(.AW(AW)) dut_i (.*);

  // behavioural reference: integers only
  function automatic void model(input int a, input bit w, input int lo, input int hi,
                                input bit ea, input bit eb, input bit outs, input bit v,
                                output bit m, output bit ha, output bit hb);
    int e;
    e = w ? (a / 2) * 2 : a;
    ha = 0; hb = 0;
    if (ea) ha = outs ? (e < lo) : (e >= lo);
    if (eb) hb = outs ? (e > hi) : (e <= hi);
    m = (ea && eb) && (outs ? (ha || hb) : (ha && hb));
    if (!v) begin m = 0; ha = 0; hb = 0; end
  endfunction

  task automatic cmp_out(input string tag, input bit m, input bit ha, input bit hb);
    checks++;
    if ({match_o, hit_a_o, hit_b_o} !== {m, ha, hb}) begin
      errors++;
      $display("FAIL %s: got match/a/b=%b%b%b expected %b%b%b", tag,
               match_o, hit_a_o, hit_b_o, m, ha, hb);
    end
  endtask

  // drive on negedge, check at following negedge (one register stage)
  task automatic step(input string tag, input bit v, input int a, input bit w,
                      input int lo, input int hi, input bit ea, input bit eb, input bit outs);
    bit m, ha, hb;
    valid_i = v; addr_i = AW'(a); word_i = w;
    cmp_a_addr_i = AW'(lo); cmp_b_addr_i = AW'(hi);
    cmp_a_en_i = ea; cmp_b_en_i = eb; outside_i = outs;
    model(a, w, lo, hi, ea, eb, outs, v, m, ha, hb);
    @(negedge clk_i);
    cmp_out(tag, m, ha, hb);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R11 reset state, with active stimulus present
    valid_i = 1; cmp_a_en_i = 1; cmp_b_en_i = 1; cmp_b_addr_i = '1;
    @(negedge clk_i);
    cmp_out("R11", 0, 0, 0);
    valid_i = 0;
    rst_ni = 1;
    @(negedge clk_i);

    // R1 inside, both hit
    step("R1", 1, 'h1000, 0, 'h0100, 'h2000, 1, 1, 0);
    // R2 below / above window
    step("R2", 1, 'h00FF, 0, 'h0100, 'h2000, 1, 1, 0);
    step("R2", 1, 'h2001, 0, 'h0100, 'h2000, 1, 1, 0);
    // R6 inclusive edges, high-bit unsigned
    step("R6", 1, 'h0100, 0, 'h0100, 'h2000, 1, 1, 0);
    step("R6", 1, 'h2000, 0, 'h0100, 'h2000, 1, 1, 0);
    step("R6", 1, 'h3FFF0, 0, 'h20000, 'h3FFF0, 1, 1, 0);
    step("R6", 1, 'h1FFFF, 0, 'h20000, 'h3FFF0, 1, 1, 0);
    // R3 outside mode
    step("R3", 1, 'h00FF, 0, 'h0100, 'h2000, 1, 1, 1);
    step("R3", 1, 'h2001, 0, 'h0100, 'h2000, 1, 1, 1);
    step("R3", 1, 'h1000, 0, 'h0100, 'h2000, 1, 1, 1);
    // R4 straddling words, inside
    step("R4", 1, 'h2001, 1, 'h0100, 'h2000, 1, 1, 0);
    step("R4", 1, 'h00FF, 1, 'h0100, 'h2000, 1, 1, 0);
    step("R4", 1, 'h0101, 1, 'h0101, 'h2000, 1, 1, 0);
    // R5 straddling words, outside
    step("R5", 1, 'h00FF, 1, 'h0100, 'h2000, 1, 1, 1);
    step("R5", 1, 'h2001, 1, 'h0100, 'h2000, 1, 1, 1);
    step("R5", 1, 'h0101, 1, 'h0101, 'h2000, 1, 1, 1);
    // R7 ends of the address space
    step("R7", 1, MAXA, 0, 'h0100, MAXA, 1, 1, 1);
    step("R7", 1, 0, 0, 0, 'h2000, 1, 1, 1);
    step("R7", 1, 0, 1, 0, MAXA, 1, 1, 1);
    // R9 disabled comparators
    step("R9", 1, 'h1000, 0, 'h0100, 'h2000, 0, 1, 0);
    step("R9", 1, 'h1000, 0, 'h0100, 'h2000, 1, 0, 0);
    step("R9", 1, 'h00FF, 0, 'h0100, 'h2000, 1, 0, 1);
    // R10 flags independent of match
    step("R10", 1, 'h3000, 0, 'h0100, 'h2000, 1, 1, 0);
    // R8 single pulse then idle
    step("R8", 1, 'h1000, 0, 'h0100, 'h2000, 1, 1, 0);
    step("R8", 0, 'h1000, 0, 'h0100, 'h2000, 1, 1, 0);
    step("R8", 0, 'h1000, 0, 'h0100, 'h2000, 1, 1, 0);

    // randomized traffic near the bounds, compared every clock
    for (int i = 0; i < 3000; i++) begin
      int lo, hi, a, pick;
      lo = $urandom_range(MAXA);
      hi = $urandom_range(MAXA);
      pick = $urandom_range(3);
      if (pick == 0) a = lo + $urandom_range(2) - 1;
      else if (pick == 1) a = hi + $urandom_range(2) - 1;
      else a = $urandom_range(MAXA);
      if (a < 0) a = 0;
      if (a > MAXA) a = MAXA;
      step("R1/R3 random", $urandom_range(3) != 0, a, $urandom_range(1) == 1, lo, hi,
           $urandom_range(5) != 0, $urandom_range(5) != 0, $urandom_range(1) == 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule